// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block sits beside the program counter of a small processor and runs counted loops with no loop-control instructions in the body. A loop-start command, seen at the fetch address together with an iteration count and the address of the last body instruction, pushes a loop context onto an internal stack. The first body address is taken as the address after the command. From then on the block compares every accepted fetch address against the end address of the innermost loop. When that address is reached and iterations remain, it overrides the next PC with the first body address and counts the pass down. The decrement and the termination test happen in hardware and use no instruction slots.

On the last pass fetch falls through to the exit address (end address plus one), the context is popped and any enclosing loop takes over again. Loops nest up to a parameter depth of six. A start that would exceed that depth is dropped and latches an overflow flag. A non-positive count never enters the loop: the block skips straight to the exit address. A body shorter than the fetch pipeline cannot refill the pipeline in time after a jump back, so the block stalls fetch for the missing cycles after each jump back. The datapath, decode and memory are outside the block.

Top module: `zol_seq`

## Requirements
- R1: After reset `loop_active_o`, `expired_o`, `overflow_o`, `stall_o`, `redirect_o` and `skip_o` are all 0.
- R2: An accepted start with a count N > 0 pushes a context whose first body address is the command address plus one, and `loop_active_o` is 1 from the following cycle.
- R3: When an accepted fetch is at the innermost end address and more than one pass remains, `redirect_o` is 1 in the same cycle with `redirect_pc_o` equal to the first body address, so the body is fetched exactly N times. A body of at least `FETCH_DEPTH` instructions adds no cycles.
- R4: On the last pass the end address produces no redirect, fetch continues at the end address plus one and the context is popped.
- R5: A start whose count, read as two's complement, is zero or negative pushes nothing: `skip_o` is 1 in that cycle and `redirect_pc_o` is the given end address plus one.
- R6: Loops nest up to `DEPTH` levels. When an inner loop finishes, the enclosing loop's count, start and end are back in force from the next cycle.
- R7: A start with a positive count while `DEPTH` loops are active is ignored, and `overflow_o` becomes 1 and stays 1 until reset.
- R8: For a body of L < `FETCH_DEPTH` instructions, each jump back is followed by `FETCH_DEPTH` - L cycles of `stall_o` = 1, during which the block accepts no fetch.
- R9: When the outermost loop exits, `loop_active_o` falls and `expired_o` is 1 for exactly one cycle. An inner loop that exits inside an outer one produces no pulse.
- R10: While `fetch_rdy_i` is 0 the block neither redirects, skips, pushes nor counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | AW | Address being fetched this cycle |
| fetch_rdy_i | input | 1 | Fetch advances this cycle |
| start_i | input | 1 | Loop-start command sits at `fetch_pc_i` |
| count_i | input | CW | Iteration count, two's complement |
| end_addr_i | input | AW | Address of the last body instruction |
| redirect_o | output | 1 | Next PC comes from `redirect_pc_o` |
| redirect_pc_o | output | AW | Override value for the next PC |
| skip_o | output | 1 | Start with non-positive count, loop skipped |
| stall_o | output | 1 | Hold fetch for pipeline refill |
| loop_active_o | output | 1 | At least one loop context is live |
| expired_o | output | 1 | One-cycle pulse after the last loop exits |
| overflow_o | output | 1 | Sticky nesting overflow |

## Verification
The bench builds the block with its defaults: a depth of six, a fetch pipeline of three and 16-bit addresses and counts. A depth of six is small enough to nest seven starts in a short program, which brings the overflow path into reach. A pipeline of three lets bodies of one and two instructions show refill stalls of two and one cycles, while three-instruction bodies run with no added cycles. A PC model in the bench follows `redirect_o` and `stall_o`, and each scenario's cycle count to the exit address is compared against a count worked out by hand.

// File: rtl/zol_pkg.sv
package zol_pkg;

  typedef enum logic [1:0] {
    START_NONE,
    START_PUSH,
    START_SKIP,
    START_OVF
  } start_act_e;

  typedef enum logic [1:0] {
    END_NONE,
    END_BACK,
    END_EXIT
  } end_act_e;

endpackage

// File: rtl/zol_stack.sv
module zol_stack #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 6,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [CW-1:0] push_cnt_i,
  input  logic [AW-1:0] push_start_i,
  input  logic [AW-1:0] push_end_i,
  input  logic          dec_i,
  input  logic          pop_i,
  output logic [CW-1:0] top_cnt_o,
  output logic [AW-1:0] top_start_o,
  output logic [AW-1:0] top_end_o,
  output logic [DW-1:0] depth_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [DW-1:0] depth_q;
  logic [CW-1:0] cnt_w   [DEPTH];
  logic [AW-1:0] start_w [DEPTH];
  logic [AW-1:0] end_w   [DEPTH];
  logic [DW-1:0] top_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     depth_q <= '0;
    else if (push_i) depth_q <= depth_q + DW'(1);
    else if (pop_i)  depth_q <= depth_q - DW'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] start_q, end_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q   <= '0;
        start_q <= '0;
        end_q   <= '0;
      end else if (push_i && depth_q == DW'(i)) begin
        cnt_q   <= push_cnt_i;
        start_q <= push_start_i;
        end_q   <= push_end_i;
      end else if (dec_i && depth_q == DW'(i + 1)) begin
        cnt_q   <= cnt_q - CW'(1);
      end
    end
    assign cnt_w[i]   = cnt_q;
    assign start_w[i] = start_q;
    assign end_w[i]   = end_q;
  end

  assign empty_o = (depth_q == '0);
  assign full_o  = (depth_q == DW'(DEPTH));
  assign depth_o = depth_q;
  assign top_idx = depth_q - DW'(1);

  always_comb begin
    top_cnt_o   = '0;
    top_start_o = '0;
    top_end_o   = '0;
    if (!empty_o) begin
      top_cnt_o   = cnt_w[top_idx];
      top_start_o = start_w[top_idx];
      top_end_o   = end_w[top_idx];
    end
  end

  a_r6_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> depth_q == $past(depth_q) + DW'(1));

  a_r4_pop_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> depth_q == $past(depth_q) - DW'(1));

  a_r7_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);

  always_comb a_r7_depth_bound: assert (depth_q <= DW'(DEPTH));

endmodule

// File: rtl/zol_refill.sv
module zol_refill #(
  parameter int AW          = 16,
  parameter int FETCH_DEPTH = 3,
  localparam int PW         = $clog2(FETCH_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          kick_i,
  input  logic [AW-1:0] body_len_i,
  output logic          stall_o
);

  if (FETCH_DEPTH > 1) begin : g_stall
    logic [PW-1:0] wait_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        wait_q <= '0;
      else if (kick_i && body_len_i < AW'(FETCH_DEPTH))
        wait_q <= PW'(AW'(FETCH_DEPTH) - body_len_i);
      else if (wait_q != '0)
        wait_q <= wait_q - PW'(1);
    end
    assign stall_o = (wait_q != '0);
  end else begin : g_nostall
    assign stall_o = 1'b0;
  end

  // a jump back can only be taken on an accepted fetch
  a_r8_no_kick_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !kick_i);

endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl import zol_pkg::*; #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          fetch_vld_i,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          full_i,
  input  logic          empty_i,
  input  logic [AW-1:0] fetch_pc_i,
  input  logic [AW-1:0] top_end_i,
  input  logic [CW-1:0] top_cnt_i,
  output start_act_e    start_act_o,
  output end_act_e      end_act_o
);

  always_comb begin
    start_act_o = START_NONE;
    if (fetch_vld_i && start_i) begin
      if ($signed(count_i) <= 0) start_act_o = START_SKIP;
      else if (full_i)           start_act_o = START_OVF;
      else                       start_act_o = START_PUSH;
    end
  end

  // a start command in the same slot takes priority over the end check
  always_comb begin
    end_act_o = END_NONE;
    if (fetch_vld_i && !empty_i && start_act_o == START_NONE &&
        fetch_pc_i == top_end_i)
      end_act_o = (top_cnt_i > CW'(1)) ? END_BACK : END_EXIT;
  end

endmodule

// File: rtl/zol_seq.sv
module zol_seq import zol_pkg::*; #(
  parameter int AW          = 16,
  parameter int CW          = 16,
  parameter int DEPTH       = 6,
  parameter int FETCH_DEPTH = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] fetch_pc_i,
  input  logic          fetch_rdy_i,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] end_addr_i,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o,
  output logic          skip_o,
  output logic          stall_o,
  output logic          loop_active_o,
  output logic          expired_o,
  output logic          overflow_o
);

  localparam int DW = $clog2(DEPTH + 1);

  logic          fetch_vld;
  start_act_e    start_act;
  end_act_e      end_act;
  logic          push, pop, dec;
  logic [CW-1:0] top_cnt;
  logic [AW-1:0] top_start, top_end, body_len;
  logic [DW-1:0] depth_w;
  logic          full_w, empty_w;
  logic          overflow_q, expired_q;

  assign fetch_vld = fetch_rdy_i && !stall_o;

  zol_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .fetch_vld_i (fetch_vld),
    .start_i     (start_i),
    .count_i     (count_i),
    .full_i      (full_w),
    .empty_i     (empty_w),
    .fetch_pc_i  (fetch_pc_i),
    .top_end_i   (top_end),
    .top_cnt_i   (top_cnt),
    .start_act_o (start_act),
    .end_act_o   (end_act)
  );

  assign push = (start_act == START_PUSH);
  assign dec  = (end_act == END_BACK);
  assign pop  = (end_act == END_EXIT);

  zol_stack #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_stack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_cnt_i   (count_i),
    .push_start_i (fetch_pc_i + AW'(1)),
    .push_end_i   (end_addr_i),
    .dec_i        (dec),
    .pop_i        (pop),
    .top_cnt_o    (top_cnt),
    .top_start_o  (top_start),
    .top_end_o    (top_end),
    .depth_o      (depth_w),
    .full_o       (full_w),
    .empty_o      (empty_w)
  );

  assign body_len = top_end - top_start + AW'(1);

  zol_refill #(.AW(AW), .FETCH_DEPTH(FETCH_DEPTH)) u_refill (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kick_i     (dec),
    .body_len_i (body_len),
    .stall_o    (stall_o)
  );

  assign skip_o        = (start_act == START_SKIP);
  assign redirect_o    = dec || skip_o;
  assign redirect_pc_o = dec ? top_start : end_addr_i + AW'(1);
  assign loop_active_o = !empty_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      overflow_q <= 1'b0;
      expired_q  <= 1'b0;
    end else begin
      if (start_act == START_OVF) overflow_q <= 1'b1;
      expired_q <= pop && (depth_w == DW'(1));
    end
  end

  assign overflow_o = overflow_q;
  assign expired_o  = expired_q;

  a_r5_skip_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> $stable(depth_w));

  a_r7_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r9_expired_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |=> !expired_o);

  a_r9_expired_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |-> !loop_active_o);

  a_r8_no_redirect_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !redirect_o);

  a_r10_idle_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_rdy_i |-> !(redirect_o || skip_o));

  a_r10_hold_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_rdy_i |=> $stable(depth_w));

endmodule

// File: tb/zol_seq_tb_top.sv
module zol_seq_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] fetch_pc_i = '0;
  logic        fetch_rdy_i = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] count_i = '0;
  logic [15:0] end_addr_i = '0;
  logic        redirect_o;
  logic [15:0] redirect_pc_o;
  logic        skip_o, stall_o, loop_active_o, expired_o, overflow_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [15:0] p_pc [8];
  logic [15:0] p_end[8];
  int          p_cnt[8];
  int          p_n;

  int n_cyc, n_watch, n_stall, n_exp, n_skip, n_bad;
  logic act2, act_end;

  always #5 clk_i = ~clk_i;

  zol_seq dut_i (
    .clk_i, .rst_ni, .fetch_pc_i, .fetch_rdy_i, .start_i, .count_i, .end_addr_i,
    .redirect_o, .redirect_pc_o, .skip_o, .stall_o, .loop_active_o,
    .expired_o, .overflow_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; fetch_rdy_i = 1'b0; start_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run_prog(input logic [15:0] first, input logic [15:0] exit_pc,
                          input logic [15:0] watch, input logic [15:0] hold_pc,
                          input int hold_n);
    logic [15:0] pc, nxt;
    logic rdy;
    int hold_left;
    pc = first; hold_left = hold_n;
    n_cyc = 0; n_watch = 0; n_stall = 0; n_exp = 0; n_skip = 0; n_bad = 0; act2 = 0;
    while (pc != exit_pc && n_cyc < 400) begin
      @(negedge clk_i);
      rdy = 1'b1;
      if (pc == hold_pc && hold_left > 0) begin rdy = 1'b0; hold_left--; end
      fetch_pc_i = pc; fetch_rdy_i = rdy;
      start_i = 1'b0; count_i = '0; end_addr_i = '0;
      for (int k = 0; k < p_n; k++)
        if (p_pc[k] == pc) begin
          start_i = 1'b1; count_i = 16'(p_cnt[k]); end_addr_i = p_end[k];
        end
      #1;
      if (n_cyc == 1) act2 = loop_active_o;
      if (expired_o) n_exp++;
      if (skip_o) n_skip++;
      if (!rdy && (redirect_o || skip_o)) n_bad++;
      if (stall_o) n_stall++;
      else if (rdy && pc == watch) n_watch++;
      nxt = (stall_o || !rdy) ? pc : (redirect_o ? redirect_pc_o : pc + 16'd1);
      @(posedge clk_i);
      pc = nxt; n_cyc++;
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      fetch_pc_i = pc; fetch_rdy_i = 1'b0; start_i = 1'b0;
      #1;
      if (expired_o) n_exp++;
    end
    act_end = loop_active_o;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 loop_active", loop_active_o, 0);
    chk("R1 expired", expired_o, 0);
    chk("R1 overflow", overflow_o, 0);
    chk("R1 stall", stall_o, 0);
    chk("R1 redirect/skip", redirect_o | skip_o, 0);
  endtask

  task automatic t_simple();
    do_reset();
    p_n = 1; p_pc[0] = 16'd10; p_end[0] = 16'd14; p_cnt[0] = 3;
    run_prog(16'd10, 16'd15, 16'd12, 16'hFFFF, 0);
    chk("R2 active after start", act2, 1);
    chk("R3 cycles N=3", n_cyc, 13);
    chk("R3 body passes", n_watch, 3);
    chk("R3 no stall long body", n_stall, 0);
    chk("R9 one expired pulse", n_exp, 1);
    chk("R9 inactive after exit", act_end, 0);
    do_reset();
    p_cnt[0] = 1;
    run_prog(16'd10, 16'd15, 16'd12, 16'hFFFF, 0);
    chk("R4 single pass cycles", n_cyc, 5);
    chk("R4 single pass body", n_watch, 1);
  endtask

  task automatic t_skip();
    do_reset();
    p_n = 1; p_pc[0] = 16'd10; p_end[0] = 16'd14; p_cnt[0] = 0;
    run_prog(16'd10, 16'd15, 16'd12, 16'hFFFF, 0);
    chk("R5 zero count cycles", n_cyc, 1);
    chk("R5 skip seen", n_skip, 1);
    chk("R5 nothing pushed", act_end, 0);
    chk("R5 no expired", n_exp, 0);
    do_reset();
    p_cnt[0] = -5;
    run_prog(16'd10, 16'd15, 16'd12, 16'hFFFF, 0);
    chk("R5 negative count cycles", n_cyc, 1);
    chk("R5 negative skip", n_skip, 1);
  endtask

  task automatic t_nested();
    do_reset();
    p_n = 2;
    p_pc[0] = 16'd20; p_end[0] = 16'd30; p_cnt[0] = 2;
    p_pc[1] = 16'd22; p_end[1] = 16'd25; p_cnt[1] = 3;
    run_prog(16'd20, 16'd31, 16'd24, 16'hFFFF, 0);
    chk("R6 nested cycles", n_cyc, 33);
    chk("R6 inner body passes", n_watch, 6);
    chk("R9 nested single pulse", n_exp, 1);
    chk("R9 nested inactive", act_end, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    p_n = 7;
    for (int k = 0; k < 6; k++) begin
      p_pc[k] = 16'(50 + k); p_end[k] = 16'(70 - k); p_cnt[k] = 1;
    end
    p_pc[6] = 16'd56; p_end[6] = 16'd64; p_cnt[6] = 2;
    run_prog(16'd50, 16'd71, 16'd60, 16'hFFFF, 0);
    chk("R7 seventh ignored cycles", n_cyc, 21);
    chk("R7 seventh body once", n_watch, 1);
    chk("R7 overflow sticky", overflow_o, 1);
    chk("R6 six deep unwinds", act_end, 0);
    do_reset();
    #1;
    chk("R7 overflow cleared by reset", overflow_o, 0);
  endtask

  task automatic t_refill();
    do_reset();
    p_n = 1; p_pc[0] = 16'd80; p_end[0] = 16'd81; p_cnt[0] = 3;
    run_prog(16'd80, 16'd82, 16'd81, 16'hFFFF, 0);
    chk("R8 len1 cycles", n_cyc, 8);
    chk("R8 len1 stall cycles", n_stall, 4);
    chk("R8 len1 body passes", n_watch, 3);
    do_reset();
    p_end[0] = 16'd82; p_cnt[0] = 2;
    run_prog(16'd80, 16'd83, 16'd81, 16'hFFFF, 0);
    chk("R8 len2 cycles", n_cyc, 6);
    chk("R8 len2 stall cycles", n_stall, 1);
  endtask

  task automatic t_ready();
    do_reset();
    p_n = 1; p_pc[0] = 16'd90; p_end[0] = 16'd93; p_cnt[0] = 2;
    run_prog(16'd90, 16'd94, 16'd92, 16'hFFFF, 0);
    chk("R3 len3 no stall", n_stall, 0);
    chk("R3 len3 cycles", n_cyc, 7);
    do_reset();
    run_prog(16'd90, 16'd94, 16'd92, 16'd93, 2);
    chk("R10 held cycles", n_cyc, 9);
    chk("R10 no redirect while held", n_bad, 0);
    chk("R10 body passes", n_watch, 2);
    do_reset();
    run_prog(16'd90, 16'd94, 16'd92, 16'd90, 2);
    chk("R10 start held", n_cyc, 9);
  endtask

  initial begin
    p_n = 0;
    t_reset();
    t_simple();
    t_skip();
    t_nested();
    t_overflow();
    t_refill();
    t_ready();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule